// File: doc/BRIEF.md
# Multichannel Banked Numerically Controlled Oscillator

This block is a time-multiplexed oscillator that serves several channels from one phase adder and one sine table. Each clock cycle is one channel slot. A full pass over all channels is one sample step. In its slot, a channel's 24-bit phase advances by that channel's phase increment. The block then emits a signed sine and cosine sample for the channel on a shared serial output, tagged with the channel number and a valid flag.

Every channel owns one increment register per bank, and there are four banks. A bank sequencer keeps one bank active for a fixed number of sample steps and then moves to the next bank in cyclic order. A 32-bit write bus reaches all sixteen increment registers at any time. Software can therefore prepare an idle bank while another bank drives the oscillator. At each step boundary, the active bank's increments are copied into a per-channel shadow. As a result, a write never changes the increment part-way through a step.

Top module: `nco_mc_banked`

## Requirements
- R1: While `rst_n` is low at a clock edge, all phases, the slot, step and bank counters and all sixteen increment registers clear to zero. Read data is zero and `out_valid` is low.
- R2: The register address is `{bank[1:0], channel[1:0]}`. A write stores `bus_wdata[23:0]` and discards bits [31:24]. `bus_rdata` returns the stored increment at `bus_addr`, zero-extended, from the edge after the write onward.
- R3: One channel slot is one clock cycle, and a step is four slots. A bank stays active for STEPS steps (default 2000). The active bank is floor(step / STEPS) mod 4, so banks run 0, 1, 2, 3, 0 and so on.
- R4: A write to a bank that is not active does not change any output sample until the sequencer next selects that bank. From then on, the new value is used.
- R5: Output samples arrive one per clock in channel order 0, 1, 2, 3, repeating, with the channel number on `out_ch`.
- R6: In its slot, a channel's phase advances by its increment modulo 2^24. The emitted sample uses the phase value from before that slot's advance.
- R7: `out_sin` is a 16-bit signed value within 2 of 32767·sin(2π(p+0.5)/1024), where p is phase bits [23:14].
- R8: `out_cos` is within 2 of 32767·cos(2π(p+0.5)/1024), with p as in R7.
- R9: A write to the active bank takes effect from the next step. A write in the last slot of a step, including the last step before a bank change, is used by the step that follows.
- R10: The sample for the slot taken at the first clock edge after reset appears after the second edge. After that, `out_valid` stays high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the increment registers |
| bus_addr | input | 4 | Register address {bank, channel}, used for both write and read |
| bus_wdata | input | 32 | Write data; bits [23:0] hold the increment |
| bus_rdata | output | 32 | Increment stored at `bus_addr`, zero-extended |
| out_valid | output | 1 | Output sample valid |
| out_ch | output | 2 | Channel of the current sample |
| out_sin | output | 16 | Signed sine sample |
| out_cos | output | 16 | Signed cosine sample |

## Verification
Two functions can fall in the same cycle: the shadow load at a step boundary and a bus write. The bench provokes this by writing in the last slot of a step, once inside a bank and once on the final step before the sequencer moves to the bank being written. A reference model in the bench applies the write before the load, which is the ordering R9 requires. Every output sample, its channel and its amplitude are then compared against that model. Writes to the active bank in mid-step and writes to an idle bank are placed so that any early pickup would shift the phase and change the sine values.

// File: rtl/nco_pkg.sv
// Package: shared defaults and the elaboration-time sine generator.
// Assumes channel and bank counts are powers of two.
package nco_pkg;
    localparam int DEF_CH    = 4;
    localparam int DEF_BANK  = 4;
    localparam int DEF_PH_W  = 24;
    localparam int DEF_BUS_W = 32;
    localparam int DEF_AMP_W = 16;
    localparam int DEF_LUT_A = 10;
    localparam int DEF_STEPS = 2000;

    // One quarter-wave entry, evaluated at the centre of its phase bin by a series sum.
    function automatic int quarter_sin(int a, int qbits, int ampw);
        real x, term, acc;
        x    = 2.0 * 3.14159265358979 * ($itor(a) + 0.5) / $itor(4 << qbits);
        term = x;
        acc  = x;
        for (int k = 1; k < 8; k++) begin
            term = -term * x * x / $itor((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * $itor((1 << (ampw - 1)) - 1) + 0.5);
    endfunction
endpackage

// File: rtl/nco_seq.sv
// Slot / step / bank sequencer.
// Slot counts channels within a step. Step count counts steps within a bank.
// next_bank is the bank the coming step will use, and is valid while step_last is high.
module nco_seq #(
    parameter int N_CH   = 4,
    parameter int N_BANK = 4,
    parameter int STEPS  = 2000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    output logic [$clog2(N_CH)-1:0]   slot,
    output logic                      step_last,
    output logic [$clog2(N_BANK)-1:0] next_bank
);
    localparam int CHW = $clog2(N_CH);
    localparam int BKW = $clog2(N_BANK);
    localparam int SCW = $clog2(STEPS + 1);

    logic [SCW-1:0] stepcnt;
    logic [BKW-1:0] bank;
    logic           bank_end;

    // Decode the end of a step and the end of a bank period.
    always_comb begin
        step_last = (slot == CHW'(N_CH - 1));
        bank_end  = step_last && (stepcnt == SCW'(STEPS - 1));
        next_bank = bank;
        if (bank_end)
            next_bank = (bank == BKW'(N_BANK - 1)) ? '0 : bank + 1'b1;
    end

    // Advance the slot every cycle, the step count per step, and the bank per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot    <= '0;
            stepcnt <= '0;
            bank    <= '0;
        end else begin
            slot <= step_last ? '0 : slot + 1'b1;
            if (step_last)
                stepcnt <= bank_end ? '0 : stepcnt + 1'b1;
            bank <= next_bank;
        end
    end

    // R5
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == CHW'(N_CH - 1)) |=> (slot == '0));
    // R3
    bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_end |=> (bank == (($past(bank) == BKW'(N_BANK - 1)) ? '0 : $past(bank) + 1'b1)));
    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_end |=> $stable(bank));
endmodule

// File: rtl/nco_incr_bank.sv
// Increment register file plus per-channel shadow.
// The register index is {bank, channel}. The shadow reloads from next_bank at each step
// end, with the same-cycle write forwarded into the load.
// Assumes single-port access: one address serves both write and read.
module nco_incr_bank #(
    parameter int N_CH   = 4,
    parameter int N_BANK = 4,
    parameter int PH_W   = 24,
    parameter int BUS_W  = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [$clog2(N_BANK)+$clog2(N_CH)-1:0] addr,
    input  logic [BUS_W-1:0]                       wr_data,
    output logic [BUS_W-1:0]                       rd_data,
    input  logic                                   load,
    input  logic [$clog2(N_BANK)-1:0]              load_bank,
    input  logic [$clog2(N_CH)-1:0]                slot,
    output logic [PH_W-1:0]                        inc_out
);
    localparam int CHW  = $clog2(N_CH);
    localparam int NREG = N_CH * N_BANK;

    logic [PH_W-1:0] regs     [NREG];
    logic [PH_W-1:0] regs_nxt [NREG];
    logic [PH_W-1:0] shadow   [N_CH];
    logic            unused_hi;

    assign unused_hi = ^wr_data[BUS_W-1:PH_W];

    // Register contents after this cycle's write, used for both storage and the shadow load.
    always_comb begin
        regs_nxt = regs;
        if (wr_en)
            regs_nxt[addr] = wr_data[PH_W-1:0];
    end

    // Store writes and reload the shadow at each step boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
            for (int c = 0; c < N_CH; c++) shadow[c] <= '0;
        end else begin
            regs <= regs_nxt;
            if (load)
                for (int c = 0; c < N_CH; c++)
                    shadow[c] <= regs_nxt[{load_bank, CHW'(c)}];
        end
    end

    // Increment for the current slot, and zero-extended readback.
    assign inc_out = shadow[slot];
    assign rd_data = BUS_W'(regs[addr]);

    // R2
    wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(addr)] == $past(wr_data[PH_W-1:0])));

    for (genvar g = 0; g < N_CH; g++) begin : g_hold
        // R9
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(shadow[g]));
    end
endmodule

// File: rtl/nco_sine_lut.sv
// Quarter-wave sine lookup, combinational.
// The table holds one quadrant at bin centres. The two top index bits pick the mirror and the sign.
module nco_sine_lut #(
    parameter int LUT_AW = 10,
    parameter int AMP_W  = 16
) (
    input  logic [LUT_AW-1:0]       idx,
    output logic signed [AMP_W-1:0] amp
);
    localparam int Q = LUT_AW - 2;

    logic signed [AMP_W-1:0] tbl [2**Q];
    logic [1:0]              quad;
    logic [Q-1:0]            a;
    logic signed [AMP_W-1:0] mag;

    for (genvar g = 0; g < 2**Q; g++) begin : g_tbl
        assign tbl[g] = AMP_W'(nco_pkg::quarter_sin(g, Q, AMP_W));
    end

    // Fold the index into the first quadrant, then restore the sign.
    always_comb begin
        quad = idx[LUT_AW-1 -: 2];
        a    = quad[0] ? ~idx[Q-1:0] : idx[Q-1:0];
        mag  = tbl[a];
        amp  = quad[1] ? -mag : mag;
    end
endmodule

// File: rtl/nco_mc_banked.sv
// Multichannel banked oscillator top level.
// Each channel has its own phase accumulator, served one slot per cycle. The output
// pipeline has two stages: phase capture, then table lookup.
// Assumes N_CH and N_BANK are powers of two and LUT_AW <= PH_W.
module nco_mc_banked #(
    parameter int N_CH   = nco_pkg::DEF_CH,
    parameter int N_BANK = nco_pkg::DEF_BANK,
    parameter int PH_W   = nco_pkg::DEF_PH_W,
    parameter int BUS_W  = nco_pkg::DEF_BUS_W,
    parameter int AMP_W  = nco_pkg::DEF_AMP_W,
    parameter int LUT_AW = nco_pkg::DEF_LUT_A,
    parameter int STEPS  = nco_pkg::DEF_STEPS
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   bus_wr,
    input  logic [$clog2(N_BANK)+$clog2(N_CH)-1:0] bus_addr,
    input  logic [BUS_W-1:0]                       bus_wdata,
    output logic [BUS_W-1:0]                       bus_rdata,
    output logic                                   out_valid,
    output logic [$clog2(N_CH)-1:0]                out_ch,
    output logic signed [AMP_W-1:0]                out_sin,
    output logic signed [AMP_W-1:0]                out_cos
);
    localparam int CHW = $clog2(N_CH);
    localparam int BKW = $clog2(N_BANK);

    logic [CHW-1:0]          slot;
    logic                    step_last;
    logic [BKW-1:0]          next_bank;
    logic [PH_W-1:0]         inc;
    logic [PH_W-1:0]         phase [N_CH];
    logic [LUT_AW-1:0]       st1_idx;
    logic [LUT_AW-1:0]       cos_idx;
    logic [CHW-1:0]          st1_ch;
    logic                    st1_v;
    logic signed [AMP_W-1:0] sin_w;
    logic signed [AMP_W-1:0] cos_w;

    nco_seq #(.N_CH(N_CH), .N_BANK(N_BANK), .STEPS(STEPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .slot(slot), .step_last(step_last), .next_bank(next_bank)
    );

    nco_incr_bank #(.N_CH(N_CH), .N_BANK(N_BANK), .PH_W(PH_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wr_data(bus_wdata),
        .rd_data(bus_rdata), .load(step_last), .load_bank(next_bank), .slot(slot), .inc_out(inc)
    );

    // Cosine reads the same table a quarter turn ahead.
    assign cos_idx = st1_idx + LUT_AW'(2**(LUT_AW - 2));

    nco_sine_lut #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_sin (.idx(st1_idx), .amp(sin_w));
    nco_sine_lut #(.LUT_AW(LUT_AW), .AMP_W(AMP_W)) u_cos (.idx(cos_idx), .amp(cos_w));

    // Advance the slot's phase, capture its old value, and register the lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < N_CH; c++) phase[c] <= '0;
            st1_idx   <= '0;
            st1_ch    <= '0;
            st1_v     <= 1'b0;
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_sin   <= '0;
            out_cos   <= '0;
        end else begin
            phase[slot] <= phase[slot] + inc;
            st1_idx     <= phase[slot][PH_W-1 -: LUT_AW];
            st1_ch      <= slot;
            st1_v       <= 1'b1;
            out_valid   <= st1_v;
            out_ch      <= st1_ch;
            out_sin     <= sin_w;
            out_cos     <= cos_w;
        end
    end

    // R5
    ch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (out_valid && (out_ch == (($past(out_ch) == CHW'(N_CH - 1)) ? '0 : $past(out_ch) + 1'b1))));
    // R10
    first_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_ch == '0));
endmodule

// File: tb/sim_nco_mc_banked.sv
`timescale 1ns/1ps
module sim_nco_mc_banked;
    localparam int S = 2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        out_valid;
    logic [1:0]  out_ch;
    logic signed [15:0] out_sin, out_cos;

    int total = 0;
    int bad   = 0;
    int cyc_done = 0;
    string phase_tag = "R3";

    int exp_ch[$];
    int exp_idx[$];
    int wq_cyc[$];
    int wq_addr[$];
    int wq_data[$];

    logic [23:0] mregs   [16];
    logic [23:0] mshadow [4];
    logic [23:0] mphase  [4];

    nco_mc_banked u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .out_valid(out_valid),
        .out_ch(out_ch), .out_sin(out_sin), .out_cos(out_cos)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc_done <= cyc_done + 1;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic int ref_amp(input int idx, input bit is_cos);
        real x, v;
        x = 2.0 * 3.14159265358979 * ($itor(idx) + 0.5) / 1024.0;
        v = 32767.0 * (is_cos ? $cos(x) : $sin(x));
        return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 2) && (b - a <= 2);
    endfunction

    // Scoreboard: compare against the queue head, then run the model one slot and push.
    always @(negedge clk) begin
        if (rst_n) begin
            if (exp_ch.size() > 0) begin
                int ech, eidx, es, ec;
                ech  = exp_ch.pop_front();
                eidx = exp_idx.pop_front();
                es   = ref_amp(eidx, 1'b0);
                ec   = ref_amp(eidx, 1'b1);
                chk(out_valid === 1'b1, "R10 valid", int'(out_valid), 1);
                chk(int'(out_ch) == ech, "R5 channel", int'(out_ch), ech);
                chk(near(int'(out_sin), es), {"R6 R7 ", phase_tag, " sin"}, int'(out_sin), es);
                chk(near(int'(out_cos), ec), {"R6 R8 ", phase_tag, " cos"}, int'(out_cos), ec);
            end else begin
                chk(out_valid === 1'b0, "R10 valid before first sample", int'(out_valid), 0);
            end
            begin
                int n, ch, k, nb;
                n = cyc_done - 1;
                while (wq_cyc.size() > 0 && wq_cyc[0] == n) begin
                    void'(wq_cyc.pop_front());
                    mregs[wq_addr.pop_front()] = 24'(wq_data.pop_front());
                end
                ch = n % 4;
                exp_ch.push_back(ch);
                exp_idx.push_back(int'(mphase[ch][23:14]));
                mphase[ch] = mphase[ch] + mshadow[ch];
                if (ch == 3) begin
                    k  = n / 4;
                    nb = ((k + 1) / S) % 4;
                    for (int c = 0; c < 4; c++) mshadow[c] = mregs[nb * 4 + c];
                end
            end
        end
    end

    // Driver: write at the edge numbered at_cyc, record it for the model, then read back.
    task automatic bus_write(input int at_cyc, input int addr, input logic [31:0] data);
        do @(negedge clk); while (cyc_done < at_cyc);
        bus_wr    = 1'b1;
        bus_addr  = 4'(addr);
        bus_wdata = data;
        wq_cyc.push_back(cyc_done);
        wq_addr.push_back(addr);
        wq_data.push_back(int'(data[23:0]));
        @(negedge clk);
        bus_wr = 1'b0;
        // R2: upper byte dropped, stored increment read back zero-extended
        chk(bus_rdata == {8'h00, data[23:0]}, "R2 readback", int'(bus_rdata), int'(data[23:0]));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mregs[i] = '0;
        for (int c = 0; c < 4; c++) begin mshadow[c] = '0; mphase[c] = '0; end
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (4) @(negedge clk);
        chk(out_valid === 1'b0, "R1 valid in reset", int'(out_valid), 0);
        chk(bus_rdata === 32'h0, "R1 reg 0 in reset", int'(bus_rdata), 0);
        bus_addr = 4'hF;
        #0.1;
        chk(bus_rdata === 32'h0, "R1 reg 15 in reset", int'(bus_rdata), 0);
        rst_n = 1'b1;
        // R3: load all banks with distinct increments, upper byte set
        for (int i = 0; i < 16; i++)
            bus_write(4 + 2 * i, i, {8'hA5, 24'(i * 24'h0A3D71 + 24'h012345)});
        // R4: idle bank 0 written while bank 3 runs
        phase_tag = "R4";
        bus_write(25001, 1, 32'h003F0000);
        // R9: active bank written mid-step, then on the last slot of a step
        phase_tag = "R9";
        bus_write(26001, 14, 32'hFF222222);
        bus_write(26003, 12, 32'h00155555);
        // R9: write on the final slot before the switch into bank 0
        bus_write(31999, 2, 32'h000ABCDE);
        phase_tag = "R4";
        do @(negedge clk); while (cyc_done < 34400);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule